// File: doc/BRIEF.md
# Transmit Short-Frame Padder

This block sits in an Ethernet transmit byte stream between a frame source and the next stage of the transmitter. Bytes move through it under valid/ready handshakes on both sides, with start-of-frame and end-of-frame markers carried alongside each byte. Frames at or above a programmable minimum length pass through untouched.

A frame that ends short of the minimum is padded only if its pad-enable flag was set on its first byte. In that case the block holds off the source and appends copies of a programmable fill byte. It moves the end-of-frame marker onto the final fill byte, so the frame leaves at exactly the minimum length.

A running count of the bytes sent in the current frame is presented at all times. CRC, preamble and descriptor handling are done elsewhere.

Top module: `tx_short_pad`

## Requirements
- R1: Outside padding the data path is combinational pass-through. `out_valid_o` equals `in_valid_i`, `out_data_o` equals `in_data_i`, `out_sof_o` equals `in_sof_i`, and `in_ready_o` equals `out_ready_i`.
- R2: A frame whose byte count is at least `min_len_i`, or whose pad flag was clear, leaves with the same bytes and no additions. Its end-of-frame marker (active high) stays on its last byte.
- R3: A pad-enabled frame of L bytes with L < `min_len_i` leaves as exactly `min_len_i` bytes. The source end-of-frame marker is not forwarded, and `out_eof_o` is high only on the last fill byte.
- R4: Every fill byte equals `pad_char_i`.
- R5: `tx_len_o` is 0 after reset. It becomes 1 when a byte with `out_sof_o` high is transferred, and rises by 1 on every other transferred output byte, fill bytes included. It holds between frames.
- R6: `in_ready_o` is low for as long as fill bytes are being produced.
- R7: While `out_ready_i` is low during padding, the current fill byte is held with `out_valid_o` high, and no fill byte is lost or repeated.
- R8: The pad flag `in_pad_en_i` is taken only from the start-of-frame byte. Its value on later bytes of the frame has no effect.
- R9: With `min_len_i` of 0 or 1, no frame is ever padded, including one-byte frames with both markers on the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| min_len_i | input | LEN_W | Minimum frame length in bytes, stable while a frame is in flight |
| pad_char_i | input | DATA_W | Fill byte value |
| in_valid_i | input | 1 | Source byte valid |
| in_ready_o | output | 1 | Source byte accepted |
| in_data_i | input | DATA_W | Source byte |
| in_sof_i | input | 1 | Source byte is first of frame |
| in_eof_i | input | 1 | Source byte is last of frame |
| in_pad_en_i | input | 1 | Pad request, meaningful with in_sof_i |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Sink accepts byte |
| out_data_o | output | DATA_W | Output byte |
| out_sof_o | output | 1 | Output byte is first of frame |
| out_eof_o | output | 1 | Output byte is last of frame |
| tx_len_o | output | LEN_W | Bytes transferred in the current frame |

## Verification
The two functions that share a cycle are the end of the source frame and the start of padding. The same handshake that accepts the source end-of-frame byte must drop its marker and switch the block to fill mode. Sink backpressure may land on that cycle or on the final fill byte. The bench provokes this with random source gaps and random sink stalls over frames of lengths one below, at, and above the minimum. It judges the result against a queue-based reference that predicts each transferred byte, its markers and the running length, with `in_ready_o` checked on every cycle in which a fill byte is due.

// File: rtl/txpad_pkg.sv
package txpad_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_FILL = 1'b1
  } txpad_state_e;
endpackage

// File: rtl/txpad_len_ctr.sv
module txpad_len_ctr #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LenMax = {LEN_W{1'b1}};

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (step_i) begin
      if (restart_i)          len_q <= LEN_W'(1);
      else if (len_q != LenMax) len_q <= len_q + LEN_W'(1);
    end
  end

  assign len_o = len_q;
endmodule

// File: rtl/txpad_ctrl.sv
module txpad_ctrl
  import txpad_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] min_len_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic             in_sof_i,
  input  logic             in_eof_i,
  input  logic             in_pad_en_i,
  input  logic             out_ready_i,
  output logic             fill_busy_o,
  output logic             fill_last_o,
  output logic             eof_drop_o
);
  localparam int unsigned CW = LEN_W + 1;

  txpad_state_e state_q, state_d;
  logic         pad_en_q;
  logic         pad_en_eff;
  logic [CW-1:0] base_len, next_len, min_ext, fill_next;
  logic         short_frame;
  logic         accept;

  // flag comes from the sof byte itself for that byte, latched copy afterwards
  assign pad_en_eff  = in_sof_i ? in_pad_en_i : pad_en_q;
  assign base_len    = in_sof_i ? '0 : {1'b0, len_i};
  assign next_len    = base_len + CW'(1);
  assign min_ext     = {1'b0, min_len_i};
  assign short_frame = pad_en_eff && (next_len < min_ext);
  assign fill_next   = {1'b0, len_i} + CW'(1);

  assign accept      = (state_q == ST_PASS) && in_valid_i && out_ready_i;
  assign eof_drop_o  = (state_q == ST_PASS) && in_eof_i && short_frame;
  assign fill_busy_o = (state_q == ST_FILL);
  assign fill_last_o = fill_next >= min_ext;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS: if (accept && eof_drop_o)        state_d = ST_FILL;
      ST_FILL: if (out_ready_i && fill_last_o)  state_d = ST_PASS;
      default:                                  state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PASS;
      pad_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && in_sof_i) pad_en_q <= in_pad_en_i;
    end
  end
endmodule

// File: rtl/txpad_out_mux.sv
module txpad_out_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              fill_busy_i,
  input  logic              fill_last_i,
  input  logic              eof_drop_i,
  input  logic [DATA_W-1:0] pad_char_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  always_comb begin
    if (fill_busy_i) begin
      in_ready_o  = 1'b0;
      out_valid_o = 1'b1;
      out_data_o  = pad_char_i;
      out_sof_o   = 1'b0;
      out_eof_o   = fill_last_i;
    end else begin
      in_ready_o  = out_ready_i;
      out_valid_o = in_valid_i;
      out_data_o  = in_data_i;
      out_sof_o   = in_sof_i;
      out_eof_o   = in_eof_i && !eof_drop_i;
    end
  end
endmodule

// File: rtl/tx_short_pad.sv
module tx_short_pad #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  min_len_i,
  input  logic [DATA_W-1:0] pad_char_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              in_pad_en_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic [LEN_W-1:0]  tx_len_o
);
  logic fill_busy, fill_last, eof_drop;

  txpad_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .min_len_i   (min_len_i),
    .len_i       (tx_len_o),
    .in_valid_i  (in_valid_i),
    .in_sof_i    (in_sof_i),
    .in_eof_i    (in_eof_i),
    .in_pad_en_i (in_pad_en_i),
    .out_ready_i (out_ready_i),
    .fill_busy_o (fill_busy),
    .fill_last_o (fill_last),
    .eof_drop_o  (eof_drop)
  );

  txpad_out_mux #(.DATA_W(DATA_W)) u_mux (
    .fill_busy_i (fill_busy),
    .fill_last_i (fill_last),
    .eof_drop_i  (eof_drop),
    .pad_char_i  (pad_char_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_sof_i    (in_sof_i),
    .in_eof_i    (in_eof_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .out_eof_o   (out_eof_o)
  );

  txpad_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (out_valid_o && out_ready_i),
    .restart_i (out_sof_o),
    .len_o     (tx_len_o)
  );
endmodule

// File: rtl/txpad_chk.sv
module txpad_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LEN_W-1:0]  min_len_i,
  input logic [DATA_W-1:0] pad_char_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_sof_o,
  input logic              out_eof_o,
  input logic [LEN_W-1:0]  tx_len_o,
  input logic              fill_busy
);
  AST_FILL_BLOCKS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_busy |-> !in_ready_o); // R6
  AST_FILL_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_busy |-> out_valid_o && out_data_o == pad_char_i && !out_sof_o); // R4
  AST_FILL_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_busy && !out_ready_i |=> fill_busy && out_valid_o && $stable(tx_len_o)); // R7
  AST_FILL_EOF_AT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_busy && out_eof_o |-> ({1'b0, tx_len_o} + 1'b1) == {1'b0, min_len_i}); // R3
  AST_LEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_sof_o && tx_len_o != {LEN_W{1'b1}}
    |=> tx_len_o == $past(tx_len_o) + 1'b1); // R5
  AST_LEN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_sof_o |=> tx_len_o == 1); // R5
endmodule

bind tx_short_pad txpad_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .min_len_i   (min_len_i),
  .pad_char_i  (pad_char_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_sof_o   (out_sof_o),
  .out_eof_o   (out_eof_o),
  .tx_len_o    (tx_len_o),
  .fill_busy   (fill_busy)
);

// File: tb/tb_tx_short_pad.sv
module tb_tx_short_pad;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 16;
  localparam int WD_CYC = 100000;

  typedef struct {
    logic [7:0] d;
    bit sof, eof, pen;
  } src_t;
  typedef struct {
    logic [7:0] d;
    bit sof, eof, pad;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LEN_W-1:0] min_len = 16'd64;
  logic [7:0] pad_char = 8'h00;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_pen = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [LEN_W-1:0] tx_len;

  always #10 clk = ~clk;

  tx_short_pad #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .min_len_i(min_len), .pad_char_i(pad_char),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .in_pad_en_i(in_pen),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof), .tx_len_o(tx_len)
  );

  src_t srcq[$];
  exp_t expq[$];
  int checks = 0, errs = 0, cyc = 0, exp_len = 0;
  bit wd_hit = 0;
  string eof_tag = "R2";

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_frame(int len, bit pen);
    bit need = pen && (len < int'(min_len));
    for (int i = 0; i < len; i++) begin
      src_t s; exp_t e;
      s.d = 8'($urandom); s.sof = (i == 0); s.eof = (i == len-1);
      s.pen = (i == 0) ? pen : 1'($urandom);
      srcq.push_back(s);
      e.d = s.d; e.sof = s.sof; e.eof = s.eof && !need; e.pad = 0;
      expq.push_back(e);
    end
    if (need)
      for (int k = len; k < int'(min_len); k++) begin
        exp_t e;
        e.d = pad_char; e.sof = 0; e.eof = (k == int'(min_len) - 1); e.pad = 1;
        expq.push_back(e);
      end
  endtask

  task automatic run_phase();
    while ((srcq.size() != 0 || expq.size() != 0) && !wd_hit) begin
      bit pad_head;
      @(negedge clk);
      cyc++;
      if (cyc > WD_CYC) begin
        wd_hit = 1;
        chk(0, "watchdog", cyc, WD_CYC);
        break;
      end
      if (srcq.size() != 0 && ($urandom % 4 != 0)) begin
        in_valid = 1; in_data = srcq[0].d; in_sof = srcq[0].sof;
        in_eof = srcq[0].eof; in_pen = srcq[0].pen;
      end else begin
        in_valid = 0; in_data = 8'($urandom); in_sof = 0; in_eof = 0; in_pen = 1'($urandom);
      end
      out_ready = ($urandom % 3 != 0);
      #2;
      chk(int'(tx_len) == exp_len, "R5 len", int'(tx_len), exp_len);
      pad_head = (expq.size() != 0) && expq[0].pad;
      if (pad_head) begin
        chk(out_valid == 1'b1, "R3 fill valid", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R6 src held", int'(in_ready), 0);
        if (!out_ready) chk(out_data == expq[0].d, "R7 stall data", int'(out_data), int'(expq[0].d));
      end else begin
        chk(out_valid == in_valid, "R1 valid", int'(out_valid), int'(in_valid));
        chk(in_ready == out_ready, "R1 ready", int'(in_ready), int'(out_ready));
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R2 extra byte", int'(out_data), -1);
        end else begin
          exp_t e = expq.pop_front();
          chk(out_data == e.d, e.pad ? "R4 fill data" : "R1 data", int'(out_data), int'(e.d));
          chk(out_sof == e.sof, "R1 sof", int'(out_sof), int'(e.sof));
          chk(out_eof == e.eof, eof_tag, int'(out_eof), int'(e.eof));
          exp_len = e.sof ? 1 : exp_len + 1;
        end
      end
      if (in_valid && in_ready && srcq.size() != 0) void'(srcq.pop_front());
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  initial begin
    out_ready = 0;
    #35;
    chk(tx_len == 0, "R5 reset len", int'(tx_len), 0);
    chk(out_valid == 0, "R1 reset valid", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    // R2/R3: lengths around a 64-byte minimum
    min_len = 16'd64; pad_char = 8'hA5; eof_tag = "R3 eof";
    add_frame(10, 1); add_frame(63, 1); add_frame(64, 1); add_frame(100, 1);
    add_frame(1, 1);
    run_phase();
    // R2: short frames with the flag clear stay unchanged; R8 later-byte flags random
    eof_tag = "R2/R8 eof";
    add_frame(5, 0); add_frame(20, 0); add_frame(7, 1);
    run_phase();
    // R4: different fill character, small minimum
    min_len = 16'd5; pad_char = 8'h3C; eof_tag = "R4/R3 eof";
    add_frame(1, 1); add_frame(4, 1); add_frame(2, 1); add_frame(5, 1); add_frame(3, 0);
    run_phase();
    // R9: minimum of 1 and 0 never pads
    min_len = 16'd1; eof_tag = "R9 eof";
    add_frame(1, 1); add_frame(2, 1); add_frame(1, 1);
    run_phase();
    min_len = 16'd0;
    add_frame(1, 1); add_frame(3, 1);
    run_phase();
    // R7: longer random mix under stalls
    min_len = 16'd16; pad_char = 8'hFF; eof_tag = "R7/R3 eof";
    for (int n = 0; n < 30; n++) add_frame(1 + int'($urandom % 24), 1'($urandom));
    run_phase();
    chk(tx_len == exp_len[LEN_W-1:0], "R5 hold idle", int'(tx_len), exp_len);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule